// File: doc/BRIEF.md
# Audio Receiver Error Logger with Sample Substitution

This block sits after the decoder of a digital audio receiver. Once per frame the decoder gives it a strobe, a set of seven error flags and the decoded audio sample. The block compares the flags with a software-written enable mask. It records the enabled errors in a status register that is cleared when read. It drives a per-frame error pin and a level interrupt. When an enabled error can damage the audio, it replaces the outgoing sample according to a selectable policy.

The control side is a simple strobe bus. A one-cycle write strobe loads the mask register. A one-cycle read strobe captures the status or the mask into a read-data register, and a read of the status register clears the bits it returned. Errors in the subcode and channel-status checksums are logged and signalled like the others, but they never change the audio sample.

Top module: `rx_err_logger`

## Requirements
- R1: After reset the status register, the mask register, the read data, the error pin, the interrupt and the output sample are all zero.
- R2: Error flag bit positions are: 0 unlock, 1 validity, 2 low confidence, 3 bi-phase violation, 4 parity, 5 subcode CRC, 6 channel-status CRC. An enabled error present on a frame strobe sets its status bit. The bit stays set across later frames until a status read.
- R3: A read strobe with select 0 loads the status register into read data, visible the cycle after the strobe, and clears exactly the bits it returned.
- R4: Mask bit 1 enables the matching error and mask bit 0 suppresses it. A suppressed error sets no status bit, leaves the error pin and the interrupt low, and leaves the sample unchanged.
- R5: An enabled error whose frame strobe coincides with a status read is kept set after the read, and the next read returns it.
- R6: The hold mode is sampled on the frame strobe. When an enabled error among bits 0 to 4 is present, mode 00 outputs the last good sample, mode 01 outputs zero and mode 10 passes the input through.
- R7: Enabled errors on bits 5 and 6 alone never change the output sample.
- R8: The error pin goes high the cycle after a frame strobe that carried any enabled error. It holds that value until the next frame strobe.
- R9: The interrupt is high exactly while any status bit is set.
- R10: The last-good-sample register takes only samples from frames with no enabled error on bits 0 to 4, and it is zero after reset.
- R11: Hold mode 11 behaves as pass-through.
- R12: A write strobe with select 1 loads the mask, and a read strobe with select 1 returns it in read data the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per decoded frame |
| err_flags | input | 7 | Per-frame error flags, valid with frame_stb |
| smp_in | input | SMP_W | Decoded audio sample, valid with frame_stb |
| hold_mode | input | 2 | Substitution policy select |
| reg_wr | input | 1 | Control write strobe |
| reg_rd | input | 1 | Control read strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | 7 | Control write data |
| reg_rdata | output | 7 | Registered read data |
| err_pin | output | 1 | Error indicator for the last frame |
| irq | output | 1 | Interrupt level |
| smp_out | output | SMP_W | Output audio sample |
| smp_out_vld | output | 1 | Output sample strobe, one cycle after frame_stb |

## Verification
The risky overlap is a status read that arrives in the same clock cycle as a frame strobe carrying an enabled error. In that cycle the clear and the set act on one register. The bench provokes this by raising the read strobe and the frame strobe together with a fresh error. It then requires that this read returns the old contents and that the following read returns the new error bit. The same overlap also settles whether the interrupt stays high after the clearing read.

// File: rtl/rxel_pkg.sv
package rxel_pkg;
    localparam int N_ERR = 7;
    // bits 0..4 may damage audio; bits 5 and 6 are checksum errors
    localparam logic [N_ERR-1:0] SMP_AFF = 7'b001_1111;

    typedef enum logic [1:0] {
        HM_REPEAT = 2'b00,
        HM_ZERO   = 2'b01,
        HM_PASS   = 2'b10,
        HM_SPARE  = 2'b11
    } hold_mode_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [N_ERR-1:0] status;
        logic [N_ERR-1:0] mask;
        logic [N_ERR-1:0] rdata;
    } stat_regs_t;
endpackage

// File: rtl/rxel_status.sv
module rxel_status
    import rxel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic [N_ERR-1:0] err_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic             sel_i,
    input  logic [N_ERR-1:0] wdata_i,
    output logic [N_ERR-1:0] hit_o,
    output logic [N_ERR-1:0] status_o,
    output logic [N_ERR-1:0] rdata_o
);
    stat_regs_t r_d, r_q;
    logic rd_stat;

    always_comb begin
        r_d     = r_q;
        hit_o   = frame_i ? (err_i & r_q.mask) : '0;
        rd_stat = rd_i && (reg_sel_e'(sel_i) == SEL_STATUS);
        // clear what is returned, keep anything arriving now
        r_d.status = (rd_stat ? '0 : r_q.status) | hit_o;
        if (wr_i && reg_sel_e'(sel_i) == SEL_MASK)
            r_d.mask = wdata_i;
        if (rd_i)
            r_d.rdata = rd_stat ? r_q.status : r_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status_o = r_q.status;
    assign rdata_o  = r_q.rdata;

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((r_q.status & $past(r_q.status)) == $past(r_q.status)));

    a_r4_masked_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !rd_stat && ((err_i & r_q.mask) == '0))
            |=> (r_q.status == $past(r_q.status)));

    a_r5_coincident_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && frame_i && ((err_i & r_q.mask) != '0)) |=> (r_q.status != '0));

    a_r3_read_returns_status: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (r_q.rdata == $past(r_q.status)));
endmodule

// File: rtl/rxel_subst.sv
module rxel_subst
    import rxel_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             aff_i,
    input  logic [1:0]       mode_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic [SMP_W-1:0] smp_o,
    output logic             vld_o
);
    typedef struct packed {
        logic [SMP_W-1:0] prev;
        logic [SMP_W-1:0] out;
        logic             vld;
    } sub_regs_t;

    sub_regs_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = frame_i;
        if (frame_i) begin
            s_d.out = smp_i;
            if (aff_i) begin
                case (hold_mode_e'(mode_i))
                    HM_REPEAT: s_d.out = s_q.prev;
                    HM_ZERO:   s_d.out = '0;
                    default:   s_d.out = smp_i;
                endcase
            end else begin
                s_d.prev = smp_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_o = s_q.out;
    assign vld_o = s_q.vld;

    a_r7_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !aff_i) |=> (smp_o == $past(smp_i)));

    a_r6_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && aff_i && mode_i == 2'b01) |=> (smp_o == '0));

    a_r10_prev_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && aff_i && mode_i == 2'b00) |=> (smp_o == $past(s_q.prev)));
endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger
    import rxel_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [6:0]       err_flags,
    input  logic [SMP_W-1:0] smp_in,
    input  logic [1:0]       hold_mode,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [6:0]       reg_wdata,
    output logic [6:0]       reg_rdata,
    output logic             err_pin,
    output logic             irq,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_out_vld
);
    logic [N_ERR-1:0] hit;
    logic [N_ERR-1:0] status;
    logic             aff;
    logic             pin_d, pin_q;

    rxel_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_stb),
        .err_i   (err_flags),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .sel_i   (reg_sel),
        .wdata_i (reg_wdata),
        .hit_o   (hit),
        .status_o(status),
        .rdata_o (reg_rdata)
    );

    assign aff = (hit & SMP_AFF) != '0;

    rxel_subst #(.SMP_W(SMP_W)) u_subst (
        .clk    (clk),
        .rst_n  (rst_n),
        .frame_i(frame_stb),
        .aff_i  (aff),
        .mode_i (hold_mode),
        .smp_i  (smp_in),
        .smp_o  (smp_out),
        .vld_o  (smp_out_vld)
    );

    always_comb begin
        pin_d = pin_q;
        if (frame_stb) pin_d = (hit != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign err_pin = pin_q;
    assign irq     = (status != '0);

    a_r8_pin_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_pin) |-> irq);

    a_r8_pin_stable_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(err_pin));
endmodule

// File: tb/rx_err_logger_tb_top.sv
module rx_err_logger_tb_top;
    localparam int SMP_W = 24;
    localparam int NV    = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_stb = 1'b0;
    logic [6:0]       err_flags = '0;
    logic [SMP_W-1:0] smp_in = '0;
    logic [1:0]       hold_mode = '0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [6:0]       reg_wdata = '0;
    logic [6:0]       reg_rdata;
    logic             err_pin, irq, smp_out_vld;
    logic [SMP_W-1:0] smp_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rx_err_logger #(.SMP_W(SMP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .err_flags(err_flags),
        .smp_in(smp_in), .hold_mode(hold_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_pin(err_pin), .irq(irq), .smp_out(smp_out), .smp_out_vld(smp_out_vld)
    );

    // {mask, mode, err, smp_in, expected smp_out, expected pin}
    localparam logic [64:0] VEC [0:NV-1] = '{
        {7'h7F, 2'd0, 7'h00, 24'h000111, 24'h000111, 1'b0}, // R10 good sample stored
        {7'h7F, 2'd0, 7'h01, 24'h000222, 24'h000111, 1'b1}, // R6 repeat
        {7'h7F, 2'd1, 7'h10, 24'h000333, 24'h000000, 1'b1}, // R6 zero
        {7'h7F, 2'd2, 7'h08, 24'h000444, 24'h000444, 1'b1}, // R6 pass
        {7'h7F, 2'd3, 7'h04, 24'h000555, 24'h000555, 1'b1}, // R11 spare
        {7'h7F, 2'd0, 7'h20, 24'h000666, 24'h000666, 1'b1}, // R7 subcode CRC
        {7'h7F, 2'd0, 7'h02, 24'h000777, 24'h000666, 1'b1}, // R10 CRC frame was good
        {7'h00, 2'd0, 7'h1F, 24'h000888, 24'h000888, 1'b0}, // R4 all masked
        {7'h7E, 2'd0, 7'h01, 24'h000999, 24'h000999, 1'b0}, // R4 one masked
        {7'h7E, 2'd0, 7'h03, 24'h000AAA, 24'h000999, 1'b1}, // R10 masked frame stored
        {7'h40, 2'd1, 7'h40, 24'h000BBB, 24'h000BBB, 1'b1}, // R7 channel-status CRC
        {7'h3F, 2'd1, 7'h40, 24'h000CCC, 24'h000CCC, 1'b0}  // R4 masked CRC
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_mask(input logic [6:0] m);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = m;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic sel);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_frame(input logic [6:0] e, input logic [1:0] m, input logic [SMP_W-1:0] s);
        @(negedge clk);
        frame_stb = 1'b1; err_flags = e; hold_mode = m; smp_in = s;
        @(negedge clk);
        frame_stb = 1'b0; err_flags = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin", {31'd0, err_pin}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 smp", {8'd0, smp_out}, 0);
        check("R1 rdata", {25'd0, reg_rdata}, 0);
        do_read(1'b1);
        check("R1 mask", {25'd0, reg_rdata}, 0);

        write_mask(7'h7F);
        do_read(1'b1);
        check("R12 mask readback", {25'd0, reg_rdata}, 32'h7F);

        // R2 accumulate, R9 irq, R3 clear on read
        do_frame(7'h05, 2'd2, 24'h1);
        check("R9 irq set", {31'd0, irq}, 1);
        do_frame(7'h10, 2'd2, 24'h2);
        do_read(1'b0);
        check("R2 accumulated", {25'd0, reg_rdata}, 32'h15);
        check("R9 irq clear", {31'd0, irq}, 0);
        do_read(1'b0);
        check("R3 cleared", {25'd0, reg_rdata}, 0);

        // R8 pin held between strobes
        do_frame(7'h01, 2'd2, 24'h3);
        check("R8 pin high", {31'd0, err_pin}, 1);
        repeat (4) @(negedge clk);
        check("R8 pin held", {31'd0, err_pin}, 1);
        do_frame(7'h00, 2'd2, 24'h4);
        check("R8 pin low", {31'd0, err_pin}, 0);
        do_read(1'b0);

        // R4 suppressed errors leave status and irq untouched
        write_mask(7'h0F);
        do_frame(7'h70, 2'd1, 24'h5);
        check("R4 pin", {31'd0, err_pin}, 0);
        check("R4 irq", {31'd0, irq}, 0);
        check("R4 smp", {8'd0, smp_out}, 32'h5);
        do_read(1'b0);
        check("R4 status", {25'd0, reg_rdata}, 0);

        // R5 error in the same cycle as a status read
        write_mask(7'h7F);
        @(negedge clk);
        frame_stb = 1'b1; err_flags = 7'h08; hold_mode = 2'd2; smp_in = 24'h6;
        reg_rd = 1'b1; reg_sel = 1'b0;
        @(negedge clk);
        frame_stb = 1'b0; err_flags = '0; reg_rd = 1'b0;
        check("R5 old value read", {25'd0, reg_rdata}, 0);
        check("R5 irq kept", {31'd0, irq}, 1);
        do_read(1'b0);
        check("R5 kept bit", {25'd0, reg_rdata}, 32'h08);

        // vector table: R6 R7 R10 R11 R4 R8
        for (int i = 0; i < NV; i++) begin
            write_mask(VEC[i][64:58]);
            do_frame(VEC[i][55:49], VEC[i][57:56], VEC[i][48:25]);
            check($sformatf("R6/R7/R10 vec%0d smp", i), {8'd0, smp_out}, {8'd0, VEC[i][24:1]});
            check($sformatf("R8 vec%0d pin", i), {31'd0, err_pin}, {31'd0, VEC[i][0]});
        end

        // R10 last-good register is zero after reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        write_mask(7'h7F);
        do_frame(7'h01, 2'd0, 24'hABCDEF);
        check("R10 prev zero after reset", {8'd0, smp_out}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule